// File: doc/BRIEF.md
# Floating-point operand unpack unit

This unit takes one packed operand and spreads it into a single internal layout that downstream arithmetic can use whatever the source format was. Five source formats are accepted: 32-bit and 64-bit two's-complement integers, and IEEE-754 single, double and 128-bit quad. A 3-bit type code picks the format, and the raw bits arrive right-justified on a 128-bit bus.

The result is a sign, a signed unbiased exponent, a 128-bit mantissa whose integer (hidden) bit always sits at bit 124, a class code and an invalid-operation flag. Integers come out in sign-magnitude form with the exponent preset so that the value's top bit lines up with bit 124. Signalling NaNs are quieted on the way through, and the unit flags them as invalid. Subnormal and integer values are not normalized here. Results are registered and appear one clock after the operand is presented.

Top module: `fp_operand_unpack`

## Requirements
- R1: Type codes are 0 int32 (bits 31:0), 1 int64 (bits 63:0), 2 single (bits 31:0), 3 double (bits 63:0), 4 quad (bits 127:0). Codes 5 to 7 set bad_type_o and force sign, exponent, mantissa, class and invalid to zero.
- R2: For every supported type, sign_o equals the top bit of the selected operand width.
- R3: A float with a zero exponent field and a zero fraction gives class 0, exponent 0 and mantissa 0.
- R4: A float with a zero exponent field and a nonzero fraction gives class 1 and exponent 1 minus the bias (127, 1023, 16383). The fraction is placed with its top bit at mantissa bit 123, and bit 124 is clear.
- R5: A normal float gives class 1 and exponent equal to the field minus the bias. The mantissa has bit 124 set and the fraction placed with its top bit at bit 123.
- R6: An all-ones exponent field with a zero fraction gives class 2, exponent 0 and mantissa 0.
- R7: An all-ones exponent field with a nonzero fraction gives class 3 and exponent 0. The mantissa holds the aligned fraction with bit 123 (the quiet bit) forced to 1. invalid_o is 1 exactly when the incoming quiet bit was 0, and no other input ever sets it.
- R8: An integer gives sign = top bit and magnitude = absolute value as unsigned, with the most negative value giving 2^31 or 2^63. The magnitude's top bit position (31 or 63) lands on mantissa bit 124, and the exponent is 31 or 63. A zero integer gives class 0, exponent 0 and mantissa 0, and a nonzero one gives class 1.
- R9: Outputs update one clock after in_valid_i is high, and out_valid_o is in_valid_i delayed by one clock. While reset is held low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operand present this cycle |
| type_i | input | 3 | Format select |
| operand_i | input | 128 | Raw packed operand, right-justified |
| out_valid_o | output | 1 | Result present |
| sign_o | output | 1 | Sign |
| exp_o | output | EXP_W (16) | Signed unbiased exponent |
| mant_o | output | MANT_W (128) | Mantissa, integer bit at MANT_W-4 |
| cls_o | output | 3 | 0 zero, 1 finite nonzero, 2 infinity, 3 NaN |
| invalid_o | output | 1 | Signalling NaN seen |
| bad_type_o | output | 1 | Unsupported type code |

## Verification
The hardest cases to reach are the ones at the edges of the exponent field, and the quiet-bit decision on NaNs, which depends on one fraction bit among up to 112. The bench therefore sweeps every float format over the edge exponents (0, 1, 2, around the bias, maximum minus one and maximum). It crosses them with fraction patterns that put the single set bit right at or just below the quiet-bit position, at the lowest bit, and at all ones, in both signs. Most-negative integers and the unsupported codes are driven directly.

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack #(
  parameter int MANT_W = 128,
  parameter int EXP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid_i,
  input  logic [2:0]               type_i,
  input  logic [127:0]             operand_i,
  output logic                     out_valid_o,
  output logic                     sign_o,
  output logic signed [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0]        mant_o,
  output logic [2:0]               cls_o,
  output logic                     invalid_o,
  output logic                     bad_type_o
);
  localparam int IBIT  = MANT_W - 4;
  localparam int FAL_W = 112;
  localparam int FSH   = IBIT - FAL_W;

  logic                    n_sign, n_inv, n_bad, is_float, emax;
  logic signed [EXP_W-1:0] n_exp;
  logic [MANT_W-1:0]       n_mant;
  logic [2:0]              n_cls;
  logic [15:0]             ef, bias;
  logic [FAL_W-1:0]        fal;
  logic [31:0]             neg32, mag32;
  logic [63:0]             neg64, mag64;

  assign neg32 = -operand_i[31:0];
  assign neg64 = -operand_i[63:0];
  assign mag32 = operand_i[31] ? neg32 : operand_i[31:0];
  assign mag64 = operand_i[63] ? neg64 : operand_i[63:0];

  always_comb begin
    n_sign = 1'b0; n_inv = 1'b0; n_bad = 1'b0; is_float = 1'b0; emax = 1'b0;
    n_exp = '0; n_mant = '0; n_cls = 3'd0;
    ef = '0; bias = '0; fal = '0;
    case (type_i)
      3'd0: begin
        n_sign = operand_i[31];
        if (mag32 != 0) begin
          n_cls  = 3'd1;
          n_exp  = EXP_W'(31);
          n_mant = MANT_W'(mag32) << (IBIT - 31);
        end
      end
      3'd1: begin
        n_sign = operand_i[63];
        if (mag64 != 0) begin
          n_cls  = 3'd1;
          n_exp  = EXP_W'(63);
          n_mant = MANT_W'(mag64) << (IBIT - 63);
        end
      end
      3'd2: begin
        is_float = 1'b1;
        n_sign = operand_i[31];
        ef   = {8'd0, operand_i[30:23]};
        emax = &operand_i[30:23];
        bias = 16'd127;
        fal  = {operand_i[22:0], 89'd0};
      end
      3'd3: begin
        is_float = 1'b1;
        n_sign = operand_i[63];
        ef   = {5'd0, operand_i[62:52]};
        emax = &operand_i[62:52];
        bias = 16'd1023;
        fal  = {operand_i[51:0], 60'd0};
      end
      3'd4: begin
        is_float = 1'b1;
        n_sign = operand_i[127];
        ef   = {1'b0, operand_i[126:112]};
        emax = &operand_i[126:112];
        bias = 16'd16383;
        fal  = operand_i[111:0];
      end
      default: n_bad = 1'b1;
    endcase

    if (is_float) begin
      if (ef == 0) begin
        if (fal != 0) begin
          n_cls  = 3'd1;
          n_exp  = EXP_W'(1 - int'(bias));
          n_mant = MANT_W'({1'b0, fal}) << FSH;
        end
      end else if (emax) begin
        if (fal == 0) begin
          n_cls = 3'd2;
        end else begin
          n_cls  = 3'd3;
          n_inv  = ~fal[FAL_W-1];
          n_mant = MANT_W'({1'b0, fal | {1'b1, {(FAL_W-1){1'b0}}}}) << FSH;
        end
      end else begin
        n_cls  = 3'd1;
        n_exp  = EXP_W'(int'(ef) - int'(bias));
        n_mant = MANT_W'({1'b1, fal}) << FSH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      sign_o      <= 1'b0;
      exp_o       <= '0;
      mant_o      <= '0;
      cls_o       <= 3'd0;
      invalid_o   <= 1'b0;
      bad_type_o  <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sign_o     <= n_sign;
        exp_o      <= n_exp;
        mant_o     <= n_mant;
        cls_o      <= n_cls;
        invalid_o  <= n_inv;
        bad_type_o <= n_bad;
      end
    end
  end

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  assert_zero_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_o == 3'd0) |-> (mant_o == '0 && exp_o == '0));
  assert_inf_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_o == 3'd2) |-> (mant_o == '0 && exp_o == '0));
  assert_nan_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_o == 3'd3) |-> (mant_o[IBIT-1] && !mant_o[IBIT]));
  assert_invalid_only_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (cls_o == 3'd3));
  assert_bad_type_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bad_type_o |-> (mant_o == '0 && cls_o == 3'd0 && !invalid_o && !sign_o));
  assert_class_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cls_o <= 3'd3);
endmodule

// File: tb/fp_operand_unpack_tb_top.sv
module fp_operand_unpack_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid_i = 1'b0;
  logic [2:0] type_i = 3'd0;
  logic [127:0] operand_i = '0;
  logic out_valid_o, sign_o, invalid_o, bad_type_o;
  logic signed [15:0] exp_o;
  logic [127:0] mant_o;
  logic [2:0] cls_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic e_sign, e_inv, e_bad;
  logic signed [15:0] e_exp;
  logic [127:0] e_mant;
  logic [2:0] e_cls;

  always #5ns clk = ~clk;

  fp_operand_unpack dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .type_i(type_i),
    .operand_i(operand_i), .out_valid_o(out_valid_o), .sign_o(sign_o),
    .exp_o(exp_o), .mant_o(mant_o), .cls_o(cls_o), .invalid_o(invalid_o),
    .bad_type_o(bad_type_o));

  task automatic compare(input string req);
    checks++;
    if (out_valid_o !== 1'b1 || sign_o !== e_sign || exp_o !== e_exp ||
        mant_o !== e_mant || cls_o !== e_cls || invalid_o !== e_inv ||
        bad_type_o !== e_bad) begin
      errors++;
      $display("FAIL %s type=%0d op=%h actual v=%b s=%b e=%0d m=%h c=%0d i=%b b=%b expected v=1 s=%b e=%0d m=%h c=%0d i=%b b=%b",
        req, type_i, operand_i, out_valid_o, sign_o, exp_o, mant_o, cls_o,
        invalid_o, bad_type_o, e_sign, e_exp, e_mant, e_cls, e_inv, e_bad);
    end
  endtask

  task automatic apply(input logic [2:0] t, input logic [127:0] op, input string req);
    @(negedge clk);
    type_i = t; operand_i = op; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    compare(req);
  endtask

  task automatic float_case(input int ew, input int fw, input logic [2:0] t,
                            input logic s, input int e, input logic [127:0] f);
    int bias = (1 << (ew - 1)) - 1;
    int emx = (1 << ew) - 1;
    logic [127:0] op = (128'(s) << (ew + fw)) | (128'(e) << fw) | f;
    logic [127:0] fa = f << (124 - fw);
    string req;
    e_sign = s; e_inv = 1'b0; e_bad = 1'b0; e_exp = '0; e_mant = '0; e_cls = 3'd0;
    if (e == 0 && f == 0) req = "R3";
    else if (e == 0) begin
      req = "R4"; e_cls = 3'd1; e_exp = 16'(1 - bias); e_mant = fa;
    end else if (e == emx && f == 0) begin
      req = "R6"; e_cls = 3'd2;
    end else if (e == emx) begin
      req = "R7"; e_cls = 3'd3; e_mant = fa | (128'd1 << 123);
      e_inv = !f[fw-1];
    end else begin
      req = "R5"; e_cls = 3'd1; e_exp = 16'(e - bias); e_mant = fa | (128'd1 << 124);
    end
    apply(t, op, s ? {req, "/R2"} : req);
  endtask

  task automatic int_case(input logic [2:0] t, input logic [63:0] v);
    int w = (t == 3'd0) ? 32 : 64;
    logic [63:0] x = (w == 32) ? {32'd0, v[31:0]} : v;
    logic neg = x[w-1];
    logic [63:0] mag = neg ? ((~x + 64'd1) & ((w == 32) ? 64'hFFFF_FFFF : '1)) : x;
    e_sign = neg; e_inv = 1'b0; e_bad = 1'b0;
    e_cls = (mag == 0) ? 3'd0 : 3'd1;
    e_exp = (mag == 0) ? 16'sd0 : 16'(w - 1);
    e_mant = (mag == 0) ? '0 : (128'(mag) << (125 - w));
    apply(t, {64'd0, x}, "R8");
  endtask

  task automatic float_sweep(input int ew, input int fw, input logic [2:0] t);
    int bias = (1 << (ew - 1)) - 1;
    int emx = (1 << ew) - 1;
    logic [127:0] ones = (128'd1 << fw) - 1;
    int elist[8];
    logic [127:0] flist[6];
    elist = '{0, 1, 2, bias - 1, bias, bias + 1, emx - 1, emx};
    flist = '{128'd0, 128'd1, 128'd1 << (fw - 1), 128'd1 << (fw - 2), ones,
              {32{4'b1010}} & ones};
    for (int s = 0; s < 2; s++)
      for (int ei = 0; ei < 8; ei++)
        for (int fi = 0; fi < 6; fi++)
          float_case(ew, fw, t, s[0], elist[ei], flist[fi]);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || sign_o !== 1'b0 || exp_o !== 16'sd0 || mant_o !== '0 ||
        cls_o !== 3'd0 || invalid_o !== 1'b0 || bad_type_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset state actual v=%b m=%h c=%0d expected all zero",
               out_valid_o, mant_o, cls_o);
    end
    rst_n = 1'b1;

    float_sweep(8, 23, 3'd2);
    float_sweep(11, 52, 3'd3);
    float_sweep(15, 112, 3'd4);

    int_case(3'd0, 64'd0);
    int_case(3'd0, 64'd1);
    int_case(3'd0, 64'hFFFF_FFFF);
    int_case(3'd0, 64'h7FFF_FFFF);
    int_case(3'd0, 64'h8000_0000);
    int_case(3'd0, 64'd123456);
    int_case(3'd0, 64'hFFFF_FFF9);
    int_case(3'd1, 64'd0);
    int_case(3'd1, 64'd1);
    int_case(3'd1, '1);
    int_case(3'd1, 64'h7FFF_FFFF_FFFF_FFFF);
    int_case(3'd1, 64'h8000_0000_0000_0000);
    int_case(3'd1, 64'h0000_0001_0000_0000);
    int_case(3'd1, 64'hFFFF_FFFF_0000_0000);

    for (int t = 5; t < 8; t++) begin
      e_sign = 1'b0; e_exp = '0; e_mant = '0; e_cls = 3'd0; e_inv = 1'b0; e_bad = 1'b1;
      apply(3'(t), '1, "R1");
    end

    @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 out_valid_o after idle actual %b expected 0", out_valid_o);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule